// File: doc/BRIEF.md
# Scaling Ratio Solver

This block works out, for one axis of an image scaler, a resize ratio that the scaler's coefficient table can hold. It receives the source length, the wanted destination length and position, and the display length. It first checks that the placement is legal. It then forms the fraction destination:source and reduces it by the greatest common divisor. If the reduced numerator still needs more table entries than exist, the destination grows by one pixel and the reduction runs again. The search stops at the first fit, or fails once the destination would exceed the display.

The caller pulses `start` while the block is idle and waits for the one-cycle `done` pulse. Each run ends in one of two ways. A fit gives the reduced numerator and denominator, the scaling direction, a resize enable and the table index value. A failure raises `err` and leaves the previous results in place. The greatest common divisor and both quotients are found by repeated subtraction, one step per clock. This keeps the arithmetic to a single subtractor per unit, and the cycle count depends on the operand sizes.

Top module: `ratio_fit`

## Requirements
- R1: After reset `busy`, `done`, `err`, `upscale` and `rsz_en` are 0, and `num`, `den` and `lut_idx` are 0.
- R2: A source length below 4 or a destination length of 0 is rejected with `err` = 1.
- R3: When `even_chk` = 1, an odd source length or an odd destination length (bit 0 set) is rejected with `err` = 1. When `even_chk` = 0, odd lengths are accepted.
- R4: A negative `dst_pos`, or `dst_pos` + destination length greater than the display length, is rejected with `err` = 1. A plane that ends exactly at the display edge is accepted.
- R5: The search starts with n = destination length and d = source length, with g = gcd(n, d). It takes the first n, counting upward, for which n ≤ 31·g (the table size is the parameter `TBL_N`). It then reports `num` = n/g and `den` = d/g with `err` = 0.
- R6: If n passes the display length before any fit is found, `err` = 1.
- R7: A run that ends with `err` = 1 leaves `num`, `den`, `upscale`, `rsz_en` and `lut_idx` at their earlier values.
- R8: `upscale` = 1 exactly when `num` > `den`. `rsz_en` = 0 exactly when `num` = `den` = 1.
- R9: `lut_idx` is 0 when `rsz_en` = 0. When `bilin_only` = 1 and the ratio is not an upscale, it is `den` − 1. In every other case it is `num` − 1.
- R10: Each accepted start produces exactly one `done` pulse, one cycle wide. `busy` rises only after a start. A `start` seen while `busy` = 1 is ignored, and inputs are latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a solve when idle |
| src_sz | input | SZ_W | Source length in pixels |
| dst_sz | input | SZ_W | Requested destination length |
| dst_pos | input | SZ_W+1 | Signed destination position |
| disp_sz | input | SZ_W | Display length on this axis |
| even_chk | input | 1 | Require even source and destination lengths |
| bilin_only | input | 1 | Filter has no bicubic mode |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run failed |
| num | output | $clog2(TBL_N+1) | Reduced numerator |
| den | output | SZ_W | Reduced denominator |
| upscale | output | 1 | Ratio enlarges the image |
| rsz_en | output | 1 | Resize needed |
| lut_idx | output | SZ_W | Table index value |

## Verification
The bench sweeps every source and destination length up to just past a small display. This covers the sizes below 4, zero and odd lengths, ratios that reduce only after the destination has grown, and the 1:1 case. A solver that compared against the table size off by one, or failed to advance n after a miss, would report a wrong numerator or an error in place of a fit. Targeted runs cover searches that run past the display, placements one pixel outside or exactly at the edge, and index selection for bilinear downscale. A start issued mid-run must neither corrupt the result nor produce a second `done`. Every failing run is checked for results that were overwritten when they should have been held.

// File: rtl/ratio_fit_pkg.sv
package ratio_fit_pkg;
  localparam int unsigned TBL_N_DEF = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRY,
    ST_GCD,
    ST_FIT,
    ST_DIVN,
    ST_DIVD
  } rf_state_e;
endpackage

// File: rtl/ratio_fit_chk.sv
module ratio_fit_chk #(
  parameter int unsigned SZ_W = 8
) (
  input  logic              [SZ_W-1:0] src_sz,
  input  logic              [SZ_W-1:0] dst_sz,
  input  logic signed       [SZ_W:0]   dst_pos,
  input  logic              [SZ_W-1:0] disp_sz,
  input  logic                         even_chk,
  output logic                         legal
);
  logic [SZ_W:0] end_pos;
  logic          too_small;
  logic          odd_bad;
  logic          off_disp;

  always_comb begin
    end_pos   = {1'b0, dst_pos[SZ_W-1:0]} + {1'b0, dst_sz};
    too_small = (src_sz < SZ_W'(4)) || (dst_sz == '0);
    odd_bad   = even_chk && (src_sz[0] || dst_sz[0]);
    off_disp  = dst_pos[SZ_W] || (end_pos > {1'b0, disp_sz});
    legal     = !too_small && !odd_bad && !off_disp;
  end
endmodule

// File: rtl/ratio_fit_gcd.sv
module ratio_fit_gcd #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] g
);
  logic [W-1:0] x_q, x_d, y_q, y_d;
  logic [W:0]   cnt_q, cnt_d;
  logic         run_q, run_d, done_q, done_d;
  logic         en;

  assign en = go || run_q;

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go) begin
      x_d   = a;
      y_d   = b;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      cnt_d = cnt_q + (W+1)'(1);
      if (x_q > y_q) begin
        x_d = x_q - y_q;
      end else if (y_q > x_q) begin
        y_d = y_q - x_q;
      end else begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (en) begin
        x_q   <= x_d;
        y_q   <= y_d;
        cnt_q <= cnt_d;
        run_q <= run_d;
      end
    end
  end

  assign done = done_q;
  assign g    = x_q;

  AST_GCD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (x_q != '0) && (y_q != '0)); // R5
  AST_GCD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q <= (W+1)'(1 << W)); // R5
endmodule

// File: rtl/ratio_fit_div.sv
module ratio_fit_div #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         done,
  output logic [W-1:0] quot
);
  logic [W-1:0] rem_q, rem_d, q_q, q_d, dvs_q, dvs_d;
  logic         run_q, run_d, done_q, done_d;
  logic         en;

  assign en = go || run_q;

  always_comb begin
    rem_d  = rem_q;
    q_d    = q_q;
    dvs_d  = dvs_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go) begin
      rem_d = dvd;
      q_d   = '0;
      dvs_d = dvs;
      run_d = 1'b1;
    end else if (run_q) begin
      if (rem_q >= dvs_q) begin
        rem_d = rem_q - dvs_q;
        q_d   = q_q + W'(1);
      end else begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_q    <= '0;
      dvs_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (en) begin
        rem_q <= rem_d;
        q_q   <= q_d;
        dvs_q <= dvs_d;
        run_q <= run_d;
      end
    end
  end

  assign done = done_q;
  assign quot = q_q;

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> dvs_q != '0); // R5
  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> rem_q == '0); // R5
endmodule

// File: rtl/ratio_fit.sv
module ratio_fit
  import ratio_fit_pkg::*;
#(
  parameter int unsigned SZ_W  = 8,
  parameter int unsigned TBL_N = TBL_N_DEF,
  localparam int unsigned NUM_W = $clog2(TBL_N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [SZ_W-1:0]        src_sz,
  input  logic [SZ_W-1:0]        dst_sz,
  input  logic signed [SZ_W:0]   dst_pos,
  input  logic [SZ_W-1:0]        disp_sz,
  input  logic                   even_chk,
  input  logic                   bilin_only,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [NUM_W-1:0]       num,
  output logic [SZ_W-1:0]        den,
  output logic                   upscale,
  output logic                   rsz_en,
  output logic [SZ_W-1:0]        lut_idx
);
  localparam int unsigned NW = SZ_W + 1;
  localparam int unsigned PW = NW + NUM_W;
  localparam logic [PW-1:0] TBL_V = PW'(TBL_N);

  rf_state_e        st_q, st_d;
  logic [NW-1:0]    n_q, n_d, g_q, g_d, qn_q, qn_d;
  logic [SZ_W-1:0]  d_q, d_d, disp_q, disp_d;
  logic             bil_q, bil_d;
  logic [NUM_W-1:0] num_q, num_d;
  logic [SZ_W-1:0]  den_q, den_d, idx_q, idx_d;
  logic             up_q, up_d, rsz_q, rsz_d, err_q, err_d, done_q, done_d;
  logic             en, legal;
  logic             gcd_go, gcd_done, div_go, div_done;
  logic [NW-1:0]    gcd_g, div_q, div_a;
  logic [PW-1:0]    prod;
  logic             fin_up, fin_rsz;

  ratio_fit_chk #(.SZ_W(SZ_W)) u_chk (
    .src_sz   (src_sz),
    .dst_sz   (dst_sz),
    .dst_pos  (dst_pos),
    .disp_sz  (disp_sz),
    .even_chk (even_chk),
    .legal    (legal)
  );

  ratio_fit_gcd #(.W(NW)) u_gcd (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (gcd_go),
    .a     (n_q),
    .b     ({1'b0, d_q}),
    .done  (gcd_done),
    .g     (gcd_g)
  );

  assign div_a = (st_q == ST_FIT) ? n_q : {1'b0, d_q};

  ratio_fit_div #(.W(NW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .dvd   (div_a),
    .dvs   (g_q),
    .done  (div_done),
    .quot  (div_q)
  );

  assign prod    = PW'(g_q) * TBL_V;
  assign fin_up  = qn_q > div_q;
  assign fin_rsz = !((qn_q == NW'(1)) && (div_q == NW'(1)));
  assign en      = start || (st_q != ST_IDLE);

  always_comb begin
    st_d   = st_q;
    n_d    = n_q;
    d_d    = d_q;
    disp_d = disp_q;
    bil_d  = bil_q;
    g_d    = g_q;
    qn_d   = qn_q;
    num_d  = num_q;
    den_d  = den_q;
    up_d   = up_q;
    rsz_d  = rsz_q;
    idx_d  = idx_q;
    err_d  = err_q;
    done_d = 1'b0;
    gcd_go = 1'b0;
    div_go = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          d_d    = src_sz;
          n_d    = {1'b0, dst_sz};
          disp_d = disp_sz;
          bil_d  = bilin_only;
          if (!legal) begin
            err_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            st_d = ST_TRY;
          end
        end
      end
      ST_TRY: begin
        if (n_q > {1'b0, disp_q}) begin
          err_d  = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          gcd_go = 1'b1;
          st_d   = ST_GCD;
        end
      end
      ST_GCD: begin
        if (gcd_done) begin
          g_d  = gcd_g;
          st_d = ST_FIT;
        end
      end
      ST_FIT: begin
        if (PW'(n_q) > prod) begin
          n_d  = n_q + NW'(1);
          st_d = ST_TRY;
        end else begin
          div_go = 1'b1;
          st_d   = ST_DIVN;
        end
      end
      ST_DIVN: begin
        if (div_done) begin
          qn_d   = div_q;
          div_go = 1'b1;
          st_d   = ST_DIVD;
        end
      end
      ST_DIVD: begin
        if (div_done) begin
          num_d = NUM_W'(qn_q);
          den_d = SZ_W'(div_q);
          up_d  = fin_up;
          rsz_d = fin_rsz;
          if (!fin_rsz) begin
            idx_d = '0;
          end else if (bil_q && !fin_up) begin
            idx_d = SZ_W'(div_q - NW'(1));
          end else begin
            idx_d = SZ_W'(qn_q - NW'(1));
          end
          err_d  = 1'b0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      n_q    <= '0;
      d_q    <= '0;
      disp_q <= '0;
      bil_q  <= 1'b0;
      g_q    <= '0;
      qn_q   <= '0;
      num_q  <= '0;
      den_q  <= '0;
      up_q   <= 1'b0;
      rsz_q  <= 1'b0;
      idx_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (en) begin
        st_q   <= st_d;
        n_q    <= n_d;
        d_q    <= d_d;
        disp_q <= disp_d;
        bil_q  <= bil_d;
        g_q    <= g_d;
        qn_q   <= qn_d;
        num_q  <= num_d;
        den_q  <= den_d;
        up_q   <= up_d;
        rsz_q  <= rsz_d;
        idx_q  <= idx_d;
        err_q  <= err_d;
      end
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign num     = num_q;
  assign den     = den_q;
  assign upscale = up_q;
  assign rsz_en  = rsz_q;
  assign lut_idx = idx_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R10
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> ($stable(num_q) && $stable(den_q) && $stable(idx_q))); // R7
  AST_NUM_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !err_q) |-> ((num_q != '0) && (PW'(num_q) <= TBL_V))); // R5
  AST_SEARCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GCD) |-> (n_q <= {1'b0, disp_q})); // R6
endmodule

// File: tb/tb_ratio_fit.sv
module tb_ratio_fit;
  localparam int SZ_W    = 8;
  localparam int CLK_PER = 10;
  localparam int NUM_W   = 5;
  localparam int WD_LIM  = 190000;

  logic                 clk, rst_n, start, even_chk, bilin_only;
  logic [SZ_W-1:0]      src_sz, dst_sz, disp_sz;
  logic signed [SZ_W:0] dst_pos;
  logic                 busy, done, err, upscale, rsz_en;
  logic [NUM_W-1:0]     num;
  logic [SZ_W-1:0]      den, lut_idx;

  int total = 0;
  int bad   = 0;
  int lg_num = 0, lg_den = 0, lg_up = 0, lg_rsz = 0, lg_idx = 0;

  ratio_fit #(.SZ_W(SZ_W), .TBL_N(31)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_sz(src_sz), .dst_sz(dst_sz),
    .dst_pos(dst_pos), .disp_sz(disp_sz), .even_chk(even_chk),
    .bilin_only(bilin_only), .busy(busy), .done(done), .err(err), .num(num),
    .den(den), .upscale(upscale), .rsz_en(rsz_en), .lut_idx(lut_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int gcd_m(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic model(input int src, input int dst, input int pos, input int disp,
                       input bit ev, output bit e_err, output string tag,
                       output int e_num, output int e_den);
    e_err = 1'b1;
    e_num = 0;
    e_den = 0;
    tag   = "R5";
    if (src < 4 || dst == 0) tag = "R2";
    else if (ev && ((src % 2) != 0 || (dst % 2) != 0)) tag = "R3";
    else if (pos < 0 || pos + dst > disp) tag = "R4";
    else begin
      tag = "R6";
      for (int n = dst; n <= disp; n++) begin
        int g = gcd_m(n, src);
        if (n <= 31 * g) begin
          e_err = 1'b0;
          e_num = n / g;
          e_den = src / g;
          tag   = "R5";
          break;
        end
      end
    end
  endtask

  task automatic drive(input int src, input int dst, input int pos, input int disp,
                       input bit ev, input bit bil);
    src_sz     = SZ_W'(src);
    dst_sz     = SZ_W'(dst);
    dst_pos    = (SZ_W+1)'(pos);
    disp_sz    = SZ_W'(disp);
    even_chk   = ev;
    bilin_only = bil;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, "R10", "done seen", int'(done), 1);
  endtask

  task automatic compare(input int src, input int dst, input int pos, input int disp,
                         input bit ev, input bit bil);
    bit e_err;
    string tag;
    int e_num, e_den, e_up, e_rsz, e_idx;
    model(src, dst, pos, disp, ev, e_err, tag, e_num, e_den);
    chk(err == e_err, tag, "err", int'(err), int'(e_err));
    if (!e_err) begin
      e_up  = (e_num > e_den) ? 1 : 0;
      e_rsz = (e_num == 1 && e_den == 1) ? 0 : 1;
      if (e_rsz == 0) e_idx = 0;
      else if (bil && e_up == 0) e_idx = e_den - 1;
      else e_idx = e_num - 1;
      lg_num = e_num; lg_den = e_den; lg_up = e_up; lg_rsz = e_rsz; lg_idx = e_idx;
      chk(int'(num) == e_num, "R5", "num", int'(num), e_num);
      chk(int'(den) == e_den, "R5", "den", int'(den), e_den);
      chk(int'(upscale) == e_up, "R8", "upscale", int'(upscale), e_up);
      chk(int'(rsz_en) == e_rsz, "R8", "rsz_en", int'(rsz_en), e_rsz);
      chk(int'(lut_idx) == e_idx, "R9", "lut_idx", int'(lut_idx), e_idx);
    end else begin
      chk(int'(num) == lg_num && int'(den) == lg_den, "R7", "held num", int'(num), lg_num);
      chk(int'(upscale) == lg_up && int'(rsz_en) == lg_rsz && int'(lut_idx) == lg_idx,
          "R7", "held idx", int'(lut_idx), lg_idx);
    end
  endtask

  task automatic run(input int src, input int dst, input int pos, input int disp,
                     input bit ev, input bit bil);
    @(negedge clk);
    drive(src, dst, pos, disp, ev, bil);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    compare(src, dst, pos, disp, ev, bil);
  endtask

  initial begin
    repeat (WD_LIM) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", WD_LIM, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    drive(0, 0, 0, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err, "R1", "flags", int'({busy, done, err}), 0);
    chk(num == '0 && den == '0 && lut_idx == '0, "R1", "values", int'(lut_idx), 0);
    chk(!upscale && !rsz_en, "R1", "modes", int'({upscale, rsz_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: R2 R5 R8 R9 and R7 on every failure
    for (int s = 0; s <= 32; s++)
      for (int d = 0; d <= 32; d++)
        run(s, d, 0, 30, (s % 3) == 0, ((s + d) % 2) == 1);

    // R3 odd lengths
    run(7, 20, 0, 100, 1'b1, 1'b0);
    run(8, 21, 0, 100, 1'b1, 1'b0);
    run(7, 21, 0, 100, 1'b0, 1'b0);
    // R4 placement and edge
    run(16, 20, -1, 100, 1'b0, 1'b0);
    run(16, 20, 10, 29, 1'b0, 1'b0);
    run(16, 20, 10, 30, 1'b0, 1'b0);
    // R6 search runs past display
    run(5, 32, 0, 33, 1'b0, 1'b0);
    run(97, 130, 0, 140, 1'b0, 1'b1);
    // R5 grow then fit, R8 upscale, R9 index choice
    run(10, 200, 0, 255, 1'b0, 1'b1);
    run(60, 20, 0, 100, 1'b0, 1'b1);
    run(60, 20, 0, 100, 1'b0, 1'b0);
    run(36, 37, 0, 60, 1'b0, 1'b0);

    // R10 start ignored while busy, single done pulse
    @(negedge clk);
    drive(97, 190, 0, 200, 1'b0, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
    @(negedge clk);
    drive(8, 8, 0, 100, 1'b0, 1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    compare(97, 190, 0, 200, 1'b0, 1'b0);
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R10", "extra done", extra, 0);
      chk(busy == 1'b0, "R10", "idle after done", int'(busy), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule